// File: doc/BRIEF.md
# CAN Controller Automatic Clock-Gating Control

This block decides, cycle by cycle, whether the internal clocks of a CAN controller may be switched off to save power. It watches a fixed idle condition made of four parts. There must be no frame on the wire. There must be no buffer traffic and no transmission waiting. There must be no CPU access. The controller must be outside the debug, low-power stop and bus-off modes. When automatic power saving is enabled and the whole condition has held for a short qualification window, the block drops its clock-enable output. That output feeds a glitch-free clock gate.

It runs on the free-running clock. It re-evaluates the condition all the time, including while the controlled clocks are stopped. So a CPU access, a bus event or a mode change raises the enable again without help from the gated domain. All activity inputs pass through a synchronizer first, because they may arrive asynchronously. The enable and the stopped-status output each come straight from a register, so they cannot glitch. The power-save enable bit belongs to the free-running domain. Clearing it turns the clocks back on after the next edge.

Top module: `can_clk_gate_ctl`

## Requirements
- R1: During reset and on the first cycles after it, `clk_en_o` is 1 and `clk_stopped_o` is 0.
- R2: While `aps_en_i` is 0, `clk_en_o` stays 1 whatever the activity inputs do.
- R3: With `aps_en_i` at 1 and all activity inputs low, `clk_en_o` falls after HOLD_CYCLES consecutive idle samples. With inputs already settled idle, this is HOLD_CYCLES rising edges after `aps_en_i` is set (default 4).
- R4: A high `frame_busy_i` prevents stopping, and restarts stopped clocks.
- R5: A high `mb_xfer_i` or `tx_pending_i` prevents stopping, and restarts stopped clocks.
- R6: A high `cpu_access_i` prevents stopping, and restarts stopped clocks, even a one-cycle strobe.
- R7: A high `debug_mode_i`, `stop_mode_i` or `bus_off_i` prevents stopping, and restarts stopped clocks.
- R8: Wake latency: an activity input driven high before edge n brings `clk_en_o` to 1 after edge n+SYNC_STAGES (default: 3 edges); it is still 0 one edge earlier.
- R9: Any busy sample during the qualification window restarts the idle count from zero.
- R10: Clearing `aps_en_i` forces `clk_en_o` to 1 after the next rising edge.
- R11: `clk_stopped_o` is always the inverse of `clk_en_o`.
- R12: After a wake, monitoring continues. Once activity ends, the clocks stop again after SYNC_STAGES+HOLD_CYCLES+1 edges from the start of a one-cycle activity pulse (default 7).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| aps_en_i | input | 1 | Automatic power-save enable (free-running domain) |
| frame_busy_i | input | 1 | Receive or transmit frame in progress |
| mb_xfer_i | input | 1 | Frame moving between serial and message buffers |
| tx_pending_i | input | 1 | A message buffer holds a frame awaiting transmission |
| cpu_access_i | input | 1 | CPU register access strobe |
| debug_mode_i | input | 1 | Controller in debug mode |
| stop_mode_i | input | 1 | Controller in low-power stop mode |
| bus_off_i | input | 1 | Controller in bus-off state |
| clk_en_o | output | 1 | Registered enable for the clock gate |
| clk_stopped_o | output | 1 | Registered status: gated clocks are stopped |

## Verification
Each output change has a fixed due cycle. A wake is due SYNC_STAGES+1 edges after the activity input rises. A restop is due SYNC_STAGES+HOLD_CYCLES+1 edges after a one-cycle pulse starts. A forced enable from clearing `aps_en_i` is due one edge later. A first stop is due HOLD_CYCLES edges after enabling with idle inputs. The driver stamps every expected value with its cycle number. It also pushes the opposite value for the cycle just before each change, so a result that comes early or late is caught. The monitor samples on the falling edge and compares only the entries due in that cycle.

// File: rtl/can_cg_pkg.sv
package can_cg_pkg;
  // activity conditions that keep the gated clocks running
  localparam int COND_NUM = 7;
  typedef enum int {
    C_FRAME = 0,
    C_XFER  = 1,
    C_TXPND = 2,
    C_CPU   = 3,
    C_DEBUG = 4,
    C_STOP  = 5,
    C_BOFF  = 6
  } cond_idx_e;
  typedef logic [COND_NUM-1:0] cond_vec_t;
endpackage

// File: rtl/can_cg_sync.sv
module can_cg_sync #(
  parameter int WIDTH  = 7,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  generate
    if (STAGES == 0) begin : g_bypass
      assign q_o = d_i;
    end else begin : g_chain
      logic [WIDTH-1:0] stg_q [STAGES];
      logic [WIDTH-1:0] stg_d [STAGES];
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
          assign stg_d[s] = d_i;
        end else begin : g_next
          assign stg_d[s] = stg_q[s-1];
        end
        // reset to "busy" so clocks stay on until real samples arrive
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg_q[s] <= '1;
          else        stg_q[s] <= stg_d[s];
        end
      end
      assign q_o = stg_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/can_cg_ctrl.sv
module can_cg_ctrl #(
  parameter int HOLD_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic aps_en_i,
  input  logic busy_i,
  output logic clk_en_o,
  output logic stopped_o
);
  localparam int CNT_W = (HOLD_CYCLES < 2) ? 1 : $clog2(HOLD_CYCLES);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HOLD_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             en_q, en_d;
  logic             stop_q;

  always_comb begin
    cnt_d = cnt_q;
    en_d  = en_q;
    if (!aps_en_i || busy_i) begin
      cnt_d = '0;
      en_d  = 1'b1;
    end else if (en_q) begin
      if (cnt_q == CNT_LAST) en_d  = 1'b0;
      else                   cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      en_q   <= 1'b1;
      stop_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      en_q   <= en_d;
      stop_q <= ~en_d;
    end
  end

  assign clk_en_o  = en_q;
  assign stopped_o = stop_q;
endmodule

// File: rtl/can_clk_gate_ctl.sv
module can_clk_gate_ctl #(
  parameter int SYNC_STAGES = 2,
  parameter int HOLD_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic aps_en_i,
  input  logic frame_busy_i,
  input  logic mb_xfer_i,
  input  logic tx_pending_i,
  input  logic cpu_access_i,
  input  logic debug_mode_i,
  input  logic stop_mode_i,
  input  logic bus_off_i,
  output logic clk_en_o,
  output logic clk_stopped_o
);
  import can_cg_pkg::*;

  // asynchronous assertion, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_core_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  cond_vec_t cond_raw, cond_sync;
  always_comb begin
    cond_raw          = '0;
    cond_raw[C_FRAME] = frame_busy_i;
    cond_raw[C_XFER]  = mb_xfer_i;
    cond_raw[C_TXPND] = tx_pending_i;
    cond_raw[C_CPU]   = cpu_access_i;
    cond_raw[C_DEBUG] = debug_mode_i;
    cond_raw[C_STOP]  = stop_mode_i;
    cond_raw[C_BOFF]  = bus_off_i;
  end

  can_cg_sync #(.WIDTH(COND_NUM), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_core_n),
    .d_i   (cond_raw),
    .q_o   (cond_sync)
  );

  can_cg_ctrl #(.HOLD_CYCLES(HOLD_CYCLES)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .aps_en_i  (aps_en_i),
    .busy_i    (|cond_sync),
    .clk_en_o  (clk_en_o),
    .stopped_o (clk_stopped_o)
  );
endmodule

// File: rtl/can_cg_checker.sv
module can_cg_checker #(
  parameter int SYNC_STAGES = 2
) (
  input logic clk,
  input logic rst_n,
  input logic aps_en_i,
  input logic frame_busy_i,
  input logic mb_xfer_i,
  input logic tx_pending_i,
  input logic cpu_access_i,
  input logic debug_mode_i,
  input logic stop_mode_i,
  input logic bus_off_i,
  input logic clk_en_o,
  input logic clk_stopped_o
);
  logic any_busy;
  assign any_busy = frame_busy_i | mb_xfer_i | tx_pending_i | cpu_access_i |
                    debug_mode_i | stop_mode_i | bus_off_i;

  assert_status_inverse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    clk_stopped_o == !clk_en_o);

  assert_disable_forces_on_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !aps_en_i |=> clk_en_o);

  assert_stop_needs_enable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(clk_en_o) |-> $past(aps_en_i));

  assert_stop_needs_qualify_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(clk_en_o) |-> $past(aps_en_i, 2));

  // R4 R5 R6 R7: the sample that allowed the stop must have been idle
  assert_stop_needs_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(clk_en_o) |-> !$past(any_busy, SYNC_STAGES + 1));
endmodule

bind can_clk_gate_ctl can_cg_checker #(.SYNC_STAGES(SYNC_STAGES)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .aps_en_i      (aps_en_i),
  .frame_busy_i  (frame_busy_i),
  .mb_xfer_i     (mb_xfer_i),
  .tx_pending_i  (tx_pending_i),
  .cpu_access_i  (cpu_access_i),
  .debug_mode_i  (debug_mode_i),
  .stop_mode_i   (stop_mode_i),
  .bus_off_i     (bus_off_i),
  .clk_en_o      (clk_en_o),
  .clk_stopped_o (clk_stopped_o)
);

// File: tb/tb_can_clk_gate_ctl.sv
module tb_can_clk_gate_ctl;
  localparam int SYNC = 2;
  localparam int HOLD = 4;

  logic clk, rst_n, aps_en;
  logic [6:0] act;
  logic clk_en, clk_stopped;

  can_clk_gate_ctl #(.SYNC_STAGES(SYNC), .HOLD_CYCLES(HOLD)) dut (
    .clk(clk), .rst_n(rst_n), .aps_en_i(aps_en),
    .frame_busy_i(act[0]), .mb_xfer_i(act[1]), .tx_pending_i(act[2]),
    .cpu_access_i(act[3]), .debug_mode_i(act[4]), .stop_mode_i(act[5]),
    .bus_off_i(act[6]), .clk_en_o(clk_en), .clk_stopped_o(clk_stopped)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct { int due; bit val; string req; } exp_t;
  exp_t q[$];
  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  function automatic void check(bit ok, string req, string what, int act_v, int exp_v);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act_v, exp_v, cyc);
    end
  endfunction

  // monitor: compares items due in the current cycle
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due <= cyc) begin
      exp_t e;
      e = q.pop_front();
      check(clk_en == e.val && clk_stopped == !e.val, e.req, "clk_en",
            int'(clk_en), int'(e.val));
    end
  end

  task automatic expect_at(int k, bit v, string req);
    exp_t e;
    e.due = cyc + k; e.val = v; e.req = req;
    q.push_back(e);
  endtask

  task automatic drain();
    while (q.size() > 0) @(negedge clk);
  endtask

  task automatic pulse(int idx);
    act[idx] = 1'b1;
    @(negedge clk);
    act[idx] = 1'b0;
  endtask

  function automatic string tag_of(int idx);
    case (idx)
      0:       return "R4";
      1, 2:    return "R5";
      3:       return "R6";
      default: return "R7";
    endcase
  endfunction

  initial begin
    rst_n = 1'b0; aps_en = 1'b0; act = '0;
    repeat (3) @(negedge clk);
    check(clk_en == 1'b1 && clk_stopped == 1'b0, "R1", "reset state", int'(clk_en), 1);
    rst_n = 1'b1;
    @(negedge clk);
    check(clk_en == 1'b1 && clk_stopped == 1'b0, "R1", "after release", int'(clk_en), 1);
    repeat (5) @(negedge clk);

    // R2: disabled, idle inputs, never stops
    expect_at(1, 1'b1, "R2");
    expect_at(10, 1'b1, "R2");
    expect_at(20, 1'b1, "R2");
    drain();

    // R3: first stop
    aps_en = 1'b1;
    expect_at(HOLD - 1, 1'b1, "R3");
    expect_at(HOLD, 1'b0, "R3");
    drain();

    // R4..R7 wake, R8 latency, R12 restop
    for (int i = 0; i < 7; i++) begin
      expect_at(SYNC, 1'b0, "R8");
      expect_at(SYNC + 1, 1'b1, tag_of(i));
      expect_at(SYNC + HOLD, 1'b1, "R12");
      expect_at(SYNC + HOLD + 1, 1'b0, "R12");
      pulse(i);
      drain();
    end

    // R9: second pulse during qualification restarts the count
    expect_at(SYNC + 1, 1'b1, "R9");
    expect_at(SYNC + HOLD + 1, 1'b1, "R9");
    expect_at(SYNC + HOLD + 3, 1'b1, "R9");
    expect_at(SYNC + HOLD + 4, 1'b0, "R9");
    pulse(3);
    @(negedge clk); @(negedge clk);
    pulse(0);
    drain();

    // R10: clearing enable while stopped
    aps_en = 1'b0;
    expect_at(1, 1'b1, "R10");
    expect_at(8, 1'b1, "R10");
    drain();
    aps_en = 1'b1;
    expect_at(HOLD, 1'b0, "R3");
    drain();

    // R10 during qualification
    pulse(1);
    repeat (SYNC + 2) @(negedge clk);
    aps_en = 1'b0;
    expect_at(1, 1'b1, "R10");
    expect_at(HOLD + 2, 1'b1, "R10");
    drain();
    aps_en = 1'b1;

    // R6: held CPU access keeps clocks running
    act[3] = 1'b1;
    expect_at(SYNC + 1, 1'b1, "R6");
    expect_at(15, 1'b1, "R6");
    expect_at(30, 1'b1, "R6");
    drain();
    act[3] = 1'b0;
    expect_at(SYNC + HOLD, 1'b0, "R12");
    drain();

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule